// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is a single-stage signed multiply-accumulate datapath for a DSP-capable execution pipeline. It has two operating modes. In halfword mode it picks one 16-bit half of each of two 32-bit sources, multiplies the two halves as signed values into a 32-bit product and adds a 32-bit accumulate operand. In word mode it multiplies the whole signed 32-bit first source by a chosen signed half of the second source. Only the upper 32 bits of the resulting 48-bit product are kept, and the accumulate operand is added to them.

An operation is accepted when `in_valid` and `exec_en` are both high in the same cycle. The sum is captured in a result register and `res_valid` pulses one cycle later. If the final signed 32-bit addition overflows, the stored result is the wrapped sum and a sticky overflow flag is set. That flag stays set until the surrounding pipeline clears it with `q_clr`. Operand fetch, decode and condition evaluation are handled outside this block. The pipeline presents its condition outcome on `exec_en`.

Top module: `smac_unit`

## Requirements
- R1: The select bit `sel_x` picks the half of `op_a` and `sel_y` picks the half of `op_b`. A value of 0 picks bits [15:0] and a value of 1 picks bits [31:16].
- R2: When `mode_word` is 0 (halfword mode), the result is the signed 16x16 product of the two selected halves plus `op_acc`, taken modulo 2^32.
- R3: In halfword mode, the unselected half of `op_a` and of `op_b` has no effect on the result or on the overflow flag. In word mode, the unselected half of `op_b` has no effect.
- R4: When `mode_word` is 1 (word mode), the result is bits [47:16] of the signed 48-bit product of `op_a` and the selected half of `op_b`, plus `op_acc`, taken modulo 2^32. Product bits [15:0] are discarded.
- R5: When the signed 32-bit accumulate addition overflows, `q_flag` is set on the clock edge that loads the result. The stored result is the wrapped sum and is not saturated.
- R6: In halfword mode, 0x8000 times 0x8000 gives the product 0x40000000. The multiplication never sets `q_flag`; only the addition can set it.
- R7: `q_flag` is sticky. Only `q_clr` clears it, and the clear is synchronous. If a clear and an overflow happen in the same cycle, the flag ends up set.
- R8: When `in_valid` is high and `exec_en` is low, `res_out` keeps its value, `q_flag` is not set, and `res_valid` stays low in the next cycle.
- R9: `res_valid` is high in exactly the cycle after a cycle in which both `in_valid` and `exec_en` are high. `res_out` updates on that same edge.
- R10: While `rst_n` is low, `res_out`, `res_valid` and `q_flag` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| exec_en | input | 1 | Condition passed; the operation is allowed to commit |
| mode_word | input | 1 | 0 = halfword by halfword, 1 = word by halfword |
| sel_x | input | 1 | Half select for op_a (0 = bits [15:0], 1 = bits [31:16]) |
| sel_y | input | 1 | Half select for op_b (0 = bits [15:0], 1 = bits [31:16]) |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| op_acc | input | 32 | Accumulate addend |
| q_clr | input | 1 | Synchronous clear of the sticky overflow flag |
| res_out | output | 32 | Registered result |
| res_valid | output | 1 | High one cycle after an accepted operation |
| q_flag | output | 1 | Sticky signed-overflow flag |

## Verification
The in-RTL assertions check on every cycle the timing and the flag behaviour:
- `res_valid` follows an accepted operation by exactly one cycle.
- The result is held while nothing is accepted.
- `q_flag` only rises after an accepted operation and only falls under a clear.
- A halfword product never reaches the one bit pattern that a signed 16x16 product cannot produce.

Arithmetic correctness can only be shown by the bench's scenarios. These compare against an independent model: the half selection, the truncation of the word-mode product, the overflow decision on the addition, and the fact that unselected halves are ignored.

// File: rtl/smac_pkg.sv
package smac_pkg;
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_e;

   typedef enum logic {
      MODE_HH = 1'b0,
      MODE_WH = 1'b1
   } mac_mode_e;
endpackage

// File: rtl/smac_half_pick.sv
module smac_half_pick #(
   parameter int W = 32,
   localparam int H = W / 2
) (
   input  logic [W-1:0] word_in,
   input  logic         sel_hi,
   output logic [H-1:0] half_out
);
   import smac_pkg::*;

   always_comb begin
      if (half_sel_e'(sel_hi) == HALF_HI) half_out = word_in[W-1:H];
      else                                half_out = word_in[H-1:0];
   end
endmodule

// File: rtl/smac_product.sv
module smac_product #(
   parameter int W        = 32,
   parameter bit WORD_ENA = 1'b1,
   localparam int H       = W / 2,
   localparam int PW      = W + H
) (
   input  logic [H-1:0] half_a,
   input  logic [W-1:0] full_a,
   input  logic [H-1:0] half_b,
   input  logic         mode_word,
   output logic [W-1:0] prod_out
);
   import smac_pkg::*;

   logic signed [W-1:0]  prod_hh;
   logic signed [PW-1:0] prod_wh_full;
   logic        [W-1:0]  prod_wh;

   always_comb prod_hh = $signed(half_a) * $signed(half_b);

   generate
      if (WORD_ENA) begin : g_word
         always_comb begin
            prod_wh_full = $signed(full_a) * $signed(half_b);
            prod_wh      = prod_wh_full[PW-1:H];
         end
      end else begin : g_noword
         always_comb begin
            prod_wh_full = '0;
            prod_wh      = '0;
         end
      end
   endgenerate

   always_comb begin
      if (mac_mode_e'(mode_word) == MODE_WH) prod_out = prod_wh;
      else                                   prod_out = prod_hh;
   end
endmodule

// File: rtl/smac_accum.sv
module smac_accum #(
   parameter int W = 32
) (
   input  logic [W-1:0] addend_p,
   input  logic [W-1:0] addend_c,
   output logic [W-1:0] sum_out,
   output logic         ovf_out
);
   always_comb begin
      sum_out = addend_p + addend_c;
      ovf_out = (addend_p[W-1] == addend_c[W-1]) && (sum_out[W-1] != addend_p[W-1]);
   end
endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
   parameter int W        = 32,
   parameter bit WORD_ENA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         exec_en,
   input  logic         mode_word,
   input  logic         sel_x,
   input  logic         sel_y,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [W-1:0] op_acc,
   input  logic         q_clr,
   output logic [W-1:0] res_out,
   output logic         res_valid,
   output logic         q_flag
);
   localparam int H = W / 2;

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_width
         $error("smac_unit: W must be even and at least 4");
      end
   endgenerate

   logic [H-1:0] half_a, half_b;
   logic [W-1:0] prod, sum;
   logic         ovf;
   logic         fire;

   assign fire = in_valid && exec_en;

   smac_half_pick #(.W(W)) u_pick_a (.word_in(op_a), .sel_hi(sel_x), .half_out(half_a));
   smac_half_pick #(.W(W)) u_pick_b (.word_in(op_b), .sel_hi(sel_y), .half_out(half_b));

   smac_product #(.W(W), .WORD_ENA(WORD_ENA)) u_prod (
      .half_a(half_a), .full_a(op_a), .half_b(half_b),
      .mode_word(mode_word), .prod_out(prod)
   );

   smac_accum #(.W(W)) u_acc (
      .addend_p(prod), .addend_c(op_acc), .sum_out(sum), .ovf_out(ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_out   <= '0;
         res_valid <= 1'b0;
         q_flag    <= 1'b0;
      end else begin
         res_valid <= fire;
         if (fire) res_out <= sum;
         q_flag <= (q_flag && !q_clr) || (fire && ovf);
      end
   end

   a_r9_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> res_valid);
   a_r8_no_valid_without_fire: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !res_valid);
   a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(res_out));
   a_r7_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag && !q_clr) |=> q_flag);
   a_r5_q_set_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_flag && !fire) |=> !q_flag);
   a_r6_hh_product_range: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !mode_word) |-> (prod[W-1:W-2] != 2'b10));
endmodule

// File: tb/smac_unit_bench.sv
module smac_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, exec_en = 1'b0, mode_word = 1'b0;
   logic        sel_x = 1'b0, sel_y = 1'b0, q_clr = 1'b0;
   logic [31:0] op_a = '0, op_b = '0, op_acc = '0;
   logic [31:0] res_out;
   logic        res_valid, q_flag;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_res = '0;
   logic        m_q = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smac_unit u_smac_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .exec_en(exec_en),
      .mode_word(mode_word), .sel_x(sel_x), .sel_y(sel_y),
      .op_a(op_a), .op_b(op_b), .op_acc(op_acc), .q_clr(q_clr),
      .res_out(res_out), .res_valid(res_valid), .q_flag(q_flag)
   );

   // returns {overflow, sum}
   function automatic logic [32:0] model(input logic md, input logic x, input logic y,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c);
      logic signed [15:0] ha, hb;
      longint pa, pb, pf;
      logic [31:0] p, s;
      logic        o;
      ha = x ? a[31:16] : a[15:0];
      hb = y ? b[31:16] : b[15:0];
      pb = longint'(hb);
      if (md) begin
         pa = longint'($signed(a));
         pf = pa * pb;
         p  = pf[47:16];
      end else begin
         pa = longint'(ha);
         pf = pa * pb;
         p  = pf[31:0];
      end
      s = p + c;
      o = (p[31] == c[31]) && (s[31] != p[31]);
      return {o, s};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic op(input string req, input logic v, input logic en, input logic md,
                     input logic x, input logic y, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] c, input logic clr);
      logic [32:0] r;
      logic        f;
      in_valid = v; exec_en = en; mode_word = md; sel_x = x; sel_y = y;
      op_a = a; op_b = b; op_acc = c; q_clr = clr;
      r = model(md, x, y, a, b, c);
      f = v && en;
      if (f) m_res = r[31:0];
      m_q = (m_q && !clr) || (f && r[32]);
      @(negedge clk);
      chk({req, " valid"}, {31'b0, res_valid}, {31'b0, f});
      chk({req, " result"}, res_out, m_res);
      chk({req, " q"}, {31'b0, q_flag}, {31'b0, m_q});
      in_valid = 1'b0; q_clr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] first;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 res", res_out, 32'h0);
      chk("R10 valid", {31'b0, res_valid}, 32'h0);
      chk("R10 q", {31'b0, q_flag}, 32'h0);
      rst_n = 1'b1;

      // R1 R2 halfword selections
      op("R1 R2 bb", 1, 1, 0, 0, 0, 32'h7777_0003, 32'h1111_FFFE, 32'd10, 0);
      op("R1 R2 tb", 1, 1, 0, 1, 0, 32'hFFFD_0001, 32'h2222_0005, 32'd1, 0);
      op("R1 R2 bt", 1, 1, 0, 0, 1, 32'h1234_0100, 32'h0200_5555, 32'h0, 0);
      op("R1 R2 tt", 1, 1, 0, 1, 1, 32'h8001_0000, 32'h7FFF_0000, 32'hFFFF_FFFF, 0);
      // R3 unselected halves ignored
      op("R3 a", 1, 1, 0, 0, 1, 32'h0000_1234, 32'h5678_0000, 32'h11, 0);
      first = res_out;
      op("R3 b", 1, 1, 0, 0, 1, 32'hDEAD_1234, 32'h5678_BEEF, 32'h11, 0);
      chk("R3 same", res_out, first);
      op("R3 word", 1, 1, 1, 0, 0, 32'h8765_4321, 32'hAAAA_F00D, 32'h5, 0);
      first = res_out;
      op("R3 word b", 1, 1, 1, 0, 0, 32'h8765_4321, 32'h1357_F00D, 32'h5, 0);
      chk("R3 word same", res_out, first);
      // R4 word mode
      op("R4 wb", 1, 1, 1, 0, 0, 32'h0001_0000, 32'h0000_0003, 32'd7, 0);
      chk("R4 wb value", res_out, 32'd10);
      op("R4 wt", 1, 1, 1, 0, 1, 32'h8000_0000, 32'h7FFF_1111, 32'h0, 0);
      op("R4 trunc", 1, 1, 1, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 0);
      chk("R4 trunc value", res_out, 32'h0);
      // R6 corner product
      op("R6 corner", 1, 1, 0, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h0, 0);
      chk("R6 corner value", res_out, 32'h4000_0000);
      chk("R6 no q", {31'b0, q_flag}, 32'h0);
      // R5 overflow wraps
      op("R5 ovf", 1, 1, 0, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 0);
      chk("R5 wrap", res_out, 32'h8000_0000);
      chk("R5 q set", {31'b0, q_flag}, 32'h1);
      // R7 sticky, clear, clear+set
      op("R7 sticky", 1, 1, 0, 0, 0, 32'h1, 32'h1, 32'h1, 0);
      chk("R7 still set", {31'b0, q_flag}, 32'h1);
      op("R7 clear+set", 1, 1, 0, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 1);
      chk("R7 set wins", {31'b0, q_flag}, 32'h1);
      op("R7 clear", 0, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 1);
      chk("R7 cleared", {31'b0, q_flag}, 32'h0);
      // R8 exec disabled
      first = res_out;
      op("R8 gated", 1, 0, 0, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 0);
      chk("R8 held", res_out, first);
      chk("R8 no q", {31'b0, q_flag}, 32'h0);
      // R9 random mix
      for (int i = 0; i < 400; i++) begin
         op("R9 R2 R4 R5 rand", 1'($urandom), ($urandom % 4) != 0, 1'($urandom),
            1'($urandom), 1'($urandom), $urandom, $urandom, $urandom,
            ($urandom % 8) == 0);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule